// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 32 device interrupt request lines plus one non-maskable request and names a single winner for the processor to service. Each device line keeps a pending flag, an enable flag and a priority level. A rising edge on a request line makes it pending. Of the lines that are pending, enabled and not masked, the one with the lowest numeric level wins; a lower level means more urgent. Masking has two parts: a global disable flag, and a base threshold that blocks every level at or above a nonzero value.

For the winner the block presents an exception number and the address of the vector word to fetch. That address is computed from a relocatable table base. The processor raises `ack` while the request is shown, and this clears the winner's pending flag. Software reaches all state through a flat word-addressed register port. Writes happen on `reg_we`, and reads are combinational on `reg_addr`:
- 0x00 sets enables (write one to set); it reads the enable vector.
- 0x01 clears enables (write one to clear); it reads the enable vector.
- 0x02 clears pending flags (write one to clear); it reads the pending vector.
- 0x03 holds the table base.
- 0x04 is the mask word: bit 8 is global disable and bits 7:0 are the threshold.
- 0x20+n holds the priority of line n in bits 7:0.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Among eligible device lines, the one with the numerically lowest priority level wins; level 0 is the most urgent.
- R2: A priority field is 8 bits wide, and only its top PRIO_BITS bits (default 3) are stored. The low 8-PRIO_BITS bits read as zero and ignore writes. The same applies to the threshold field.
- R3: Device line n is reported as exception number 16+n. The non-maskable request is reported as exception number 2.
- R4: The vector address for device line n is base + 0x40 + 4*n. For the non-maskable request it is base + 0x08.
- R5: The table base resets to TBL_RESET (default 0x0000_1000). Bits 1:0 always read as zero.
- R6: While global disable (mask word bit 8) is set, no device line is requested.
- R7: With a nonzero threshold T, a device line whose level is >= T is not requested. A threshold of zero masks nothing.
- R8: Writing ones to 0x00 sets enables and writing ones to 0x01 clears them. A disabled line is never requested but keeps its pending flag.
- R9: The non-maskable input has top urgency and ignores global disable and the threshold. The output reflects it one cycle after it is sampled high.
- R10: A pending flag is set only by a rising request edge; a held level does not set it again. It is cleared when the line is acknowledged, or when a one is written to its bit at 0x02.
- R11: When two eligible lines share a level, the lower line number wins.
- R12: `irq_valid`, `exc_num` and `vec_addr` are registered. They change in the cycle after a change to pending, enable, priority or mask state, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_IRQ | Device request lines, edge-detected |
| nmi | input | 1 | Non-maskable request, level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ack | input | 1 | Processor takes the shown request |
| irq_valid | output | 1 | A request is presented |
| exc_num | output | 8 | Exception number of the winner |
| vec_addr | output | 32 | Vector fetch address of the winner |

## Verification
The bench goes after equal-level ties, checking that the lower line wins. A design with the loop compare inverted would pick the higher line. It tests a priority that equals the threshold, which must be blocked; an off-by-one compare would let it through. It writes priorities with junk low bits, which must not split a tie; a design that stores those bits would break the tie by them. It also covers a held request line across an acknowledge, which must not pend again, and a level-triggered design would re-raise it. Finally it samples the output exactly one cycle after an enable write, so an extra or missing register stage shows up. The non-maskable request is checked under global disable and threshold masking together.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int REG_AW = 6;

    typedef enum logic [REG_AW-1:0] {
        RA_EN_SET   = 6'h00,
        RA_EN_CLR   = 6'h01,
        RA_PEND_CLR = 6'h02,
        RA_BASE     = 6'h03,
        RA_MASK     = 6'h04
    } reg_addr_e;

    localparam logic [REG_AW-1:0] RA_PRIO0 = 6'h20;
    localparam int                MASK_GDIS_BIT = 8;

    localparam logic [7:0]  EXC_NMI  = 8'd2;
    localparam logic [7:0]  EXC_DEV0 = 8'd16;
    localparam logic [31:0] OFS_NMI  = 32'h08;
    localparam logic [31:0] OFS_DEV0 = 32'h40;

    typedef struct packed {
        logic        valid;
        logic [7:0]  exc;
        logic [31:0] addr;
    } vec_out_t;

    function automatic logic [7:0] dev_exc(input logic [4:0] id);
        return EXC_DEV0 + {3'd0, id};
    endfunction

    function automatic logic [31:0] dev_offset(input logic [4:0] id);
        return OFS_DEV0 + {25'd0, id, 2'b00};
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int          NUM_IRQ   = 32,
    parameter int          PRIO_BITS = 3,
    parameter logic [31:0] TBL_RESET = 32'h0000_1000,
    localparam int         IDW       = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [REG_AW-1:0]             addr,
    input  logic [31:0]                   wdata,
    output logic [31:0]                   rdata,
    input  logic [NUM_IRQ-1:0]            irq_req,
    input  logic                          ack_clr,
    input  logic [IDW-1:0]                ack_id,
    output logic [NUM_IRQ-1:0]            en_q,
    output logic [NUM_IRQ-1:0]            pend_q,
    output logic [NUM_IRQ*PRIO_BITS-1:0]  prio_flat,
    output logic [31:0]                   base_q,
    output logic                          gdis_q,
    output logic [PRIO_BITS-1:0]          thr_q
);
    localparam int LOWB = 8 - PRIO_BITS;

    logic [NUM_IRQ-1:0]   req_d, rise, ack_mask, sw_clr;
    logic [PRIO_BITS-1:0] prio_q [NUM_IRQ];

    always_ff @(posedge clk) begin
        if (rst) req_d <= '0;
        else     req_d <= irq_req;
    end

    assign rise = irq_req & ~req_d;

    always_comb begin
        ack_mask = '0;
        if (ack_clr) ack_mask[ack_id] = 1'b1;
    end

    assign sw_clr = (we && addr == RA_PEND_CLR) ? wdata[NUM_IRQ-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
            base_q <= TBL_RESET & 32'hFFFF_FFFC;
            gdis_q <= 1'b0;
            thr_q  <= '0;
        end else begin
            pend_q <= rise | (pend_q & ~(ack_mask | sw_clr));
            if (we && addr == RA_EN_SET) en_q <= en_q | wdata[NUM_IRQ-1:0];
            if (we && addr == RA_EN_CLR) en_q <= en_q & ~wdata[NUM_IRQ-1:0];
            if (we && addr == RA_BASE)   base_q <= {wdata[31:2], 2'b00};
            if (we && addr == RA_MASK) begin
                gdis_q <= wdata[MASK_GDIS_BIT];
                thr_q  <= wdata[7:LOWB];
            end
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst)                                         prio_q[g] <= '0;
            else if (we && addr == RA_PRIO0 + REG_AW'(g))    prio_q[g] <= wdata[7:LOWB];
        end
        assign prio_flat[g*PRIO_BITS +: PRIO_BITS] = prio_q[g];
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_EN_SET, RA_EN_CLR: rdata[NUM_IRQ-1:0] = en_q;
            RA_PEND_CLR:          rdata[NUM_IRQ-1:0] = pend_q;
            RA_BASE:              rdata = base_q;
            RA_MASK: begin
                rdata[MASK_GDIS_BIT] = gdis_q;
                rdata[7:0]           = 8'(thr_q) << LOWB;
            end
            default: begin
                for (int i = 0; i < NUM_IRQ; i++)
                    if (addr == RA_PRIO0 + REG_AW'(i)) rdata[7:0] = 8'(prio_q[i]) << LOWB;
            end
        endcase
    end

    // R10: an acknowledge without a coincident new edge leaves the line clear
    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (ack_clr && !rise[ack_id]) |=> !pend_q[$past(ack_id)]);

    // R8: bits written to the clear-enable word are off afterwards
    assert_en_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (we && addr == RA_EN_CLR) |=> ((en_q & $past(wdata[NUM_IRQ-1:0])) == '0));

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int  NUM_IRQ   = 32,
    parameter int  PRIO_BITS = 3,
    localparam int IDW       = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0]           pend,
    input  logic [NUM_IRQ-1:0]           en,
    input  logic [NUM_IRQ*PRIO_BITS-1:0] prio_flat,
    input  logic                         gdis,
    input  logic [PRIO_BITS-1:0]         thr,
    output logic                         hit,
    output logic [IDW-1:0]               win_id
);
    logic [PRIO_BITS-1:0] best;
    logic [PRIO_BITS-1:0] lvl;
    logic                 elig;

    // strict less-than keeps the lower index on equal levels
    always_comb begin
        hit    = 1'b0;
        win_id = '0;
        best   = '1;
        lvl    = '0;
        elig   = 1'b0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            lvl  = prio_flat[i*PRIO_BITS +: PRIO_BITS];
            elig = pend[i] && en[i] && !gdis && ((thr == '0) || (lvl < thr));
            if (elig && (!hit || lvl < best)) begin
                hit    = 1'b1;
                best   = lvl;
                win_id = IDW'(i);
            end
        end
    end

    // R7: a chosen line is always below a nonzero threshold
    always_comb begin
        if (hit && thr != '0)
            assert_thr_R7: assert (prio_flat[win_id*PRIO_BITS +: PRIO_BITS] < thr);
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int          NUM_IRQ   = 32,
    parameter int          PRIO_BITS = 3,
    parameter logic [31:0] TBL_RESET = 32'h0000_1000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               nmi,
    input  logic               reg_we,
    input  logic [5:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               ack,
    output logic               irq_valid,
    output logic [7:0]         exc_num,
    output logic [31:0]        vec_addr
);
    localparam int IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic [NUM_IRQ-1:0]           en_q, pend_q;
    logic [NUM_IRQ*PRIO_BITS-1:0] prio_flat;
    logic [31:0]                  base_q;
    logic                         gdis_q;
    logic [PRIO_BITS-1:0]         thr_q;
    logic                         hit;
    logic [IDW-1:0]               win_id, cur_id;
    logic                         ack_clr;
    vec_out_t                     out_d, out_q;

    assign cur_id  = IDW'(out_q.exc - EXC_DEV0);
    assign ack_clr = ack && out_q.valid && (out_q.exc != EXC_NMI);

    irqc_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .TBL_RESET(TBL_RESET)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .irq_req(irq_req), .ack_clr(ack_clr), .ack_id(cur_id),
        .en_q(en_q), .pend_q(pend_q), .prio_flat(prio_flat), .base_q(base_q),
        .gdis_q(gdis_q), .thr_q(thr_q)
    );

    irqc_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_arb (
        .pend(pend_q), .en(en_q), .prio_flat(prio_flat), .gdis(gdis_q),
        .thr(thr_q), .hit(hit), .win_id(win_id)
    );

    always_comb begin
        out_d = '0;
        if (nmi) begin
            out_d.valid = 1'b1;
            out_d.exc   = EXC_NMI;
            out_d.addr  = base_q + OFS_NMI;
        end else if (hit) begin
            out_d.valid = 1'b1;
            out_d.exc   = dev_exc(5'(win_id));
            out_d.addr  = base_q + dev_offset(5'(win_id));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign irq_valid = out_q.valid;
    assign exc_num   = out_q.exc;
    assign vec_addr  = out_q.addr;

    logic [NUM_IRQ-1:0] live;
    assign live = en_q & pend_q;

    // R9: a sampled non-maskable request is shown on the next cycle
    assert_nmi_first_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(nmi)) |-> (irq_valid && exc_num == EXC_NMI));

    // R6: no device request follows a cycle with global disable set
    assert_gdis_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && irq_valid && exc_num != EXC_NMI) |-> !$past(gdis_q));

    // R4: device vector equals base plus four times the exception number
    assert_vec_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && irq_valid && exc_num != EXC_NMI)
            |-> (vec_addr == $past(base_q) + {22'd0, exc_num, 2'b00}));

    // R8: a shown device line was enabled and pending one cycle earlier
    assert_win_live_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && irq_valid && exc_num != EXC_NMI) |-> (($past(live) >> cur_id) & 1) != 0);

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
    localparam logic [31:0] TBL_RESET = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] irq_req;
    logic        nmi, reg_we, ack;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata, vec_addr;
    logic        irq_valid;
    logic [7:0]  exc_num;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl #(.NUM_IRQ(32), .PRIO_BITS(3), .TBL_RESET(TBL_RESET)) dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .nmi(nmi), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ack(ack), .irq_valid(irq_valid), .exc_num(exc_num), .vec_addr(vec_addr)
    );

    typedef struct packed {
        logic [4:0] ia;
        logic [7:0] pa;
        logic [4:0] ib;
        logic [7:0] pb;
        logic [7:0] thr;
        logic       gd;
        logic       ev;
        logic [7:0] ee;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{5'd3,  8'h40, 5'd7,  8'h20, 8'h00, 1'b0, 1'b1, 8'd23},
        '{5'd5,  8'h60, 5'd2,  8'h60, 8'h00, 1'b0, 1'b1, 8'd18},
        '{5'd9,  8'h5F, 5'd4,  8'h40, 8'h00, 1'b0, 1'b1, 8'd20},
        '{5'd1,  8'h80, 5'd30, 8'h00, 8'h00, 1'b0, 1'b1, 8'd46},
        '{5'd3,  8'h60, 5'd6,  8'h80, 8'h60, 1'b0, 1'b0, 8'd0},
        '{5'd3,  8'h40, 5'd6,  8'h20, 8'h60, 1'b0, 1'b1, 8'd22},
        '{5'd3,  8'h40, 5'd6,  8'h60, 8'h40, 1'b0, 1'b0, 8'd0},
        '{5'd0,  8'h00, 5'd31, 8'h00, 8'h00, 1'b1, 1'b0, 8'd0},
        '{5'd31, 8'hE0, 5'd0,  8'hE0, 8'h00, 1'b0, 1'b1, 8'd16}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] m);
        @(negedge clk);
        irq_req = m;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cleanup();
        wr(6'h01, 32'hFFFF_FFFF);
        wr(6'h02, 32'hFFFF_FFFF);
        wr(6'h04, 32'h0);
        settle();
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; irq_req = '0; nmi = 1'b0; reg_we = 1'b0;
        reg_addr = '0; reg_wdata = '0; ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check("R12 reset valid", {31'd0, irq_valid}, 32'd0);
        rd(6'h03, d); check("R5 reset base", d, TBL_RESET);
        rd(6'h00, d); check("R8 reset enables", d, 32'd0);
        rd(6'h02, d); check("R10 reset pending", d, 32'd0);

        // R2 low bits of priority dropped
        wr(6'h25, 32'h0000_00FF);
        rd(6'h25, d); check("R2 prio readback", d, 32'h0000_00E0);
        wr(6'h25, 32'h0);
        wr(6'h04, 32'h0000_007F);
        rd(6'h04, d); check("R2 threshold readback", d, 32'h0000_0060);
        wr(6'h04, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr(6'h20 + 6'(TBL[i].ia), {24'd0, TBL[i].pa});
            wr(6'h20 + 6'(TBL[i].ib), {24'd0, TBL[i].pb});
            wr(6'h04, {23'd0, TBL[i].gd, TBL[i].thr});
            wr(6'h00, (32'd1 << TBL[i].ia) | (32'd1 << TBL[i].ib));
            pulse((32'd1 << TBL[i].ia) | (32'd1 << TBL[i].ib));
            settle();
            check($sformatf("R1 R6 R7 R11 row %0d valid", i), {31'd0, irq_valid}, {31'd0, TBL[i].ev});
            if (TBL[i].ev) begin
                check($sformatf("R3 row %0d exc", i), {24'd0, exc_num}, {24'd0, TBL[i].ee});
                check($sformatf("R4 row %0d addr", i), vec_addr,
                      TBL_RESET + 32'h40 + 32'd4 * ({24'd0, TBL[i].ee} - 32'd16));
            end
            wr(6'h20 + 6'(TBL[i].ia), 32'h0);
            wr(6'h20 + 6'(TBL[i].ib), 32'h0);
            cleanup();
        end

        // R12 timing and R8 enable control on line 12
        pulse(32'd1 << 12);
        settle();
        check("R8 disabled not requested", {31'd0, irq_valid}, 32'd0);
        rd(6'h02, d); check("R8 disabled stays pending", d, 32'd1 << 12);
        wr(6'h00, 32'd1 << 12);
        check("R12 no change before one cycle", {31'd0, irq_valid}, 32'd0);
        @(negedge clk);
        check("R12 change after one cycle", {31'd0, irq_valid}, 32'd1);
        check("R3 line 12 exc", {24'd0, exc_num}, 32'd28);
        wr(6'h01, 32'd1 << 12);
        check("R12 disable not before one cycle", {31'd0, irq_valid}, 32'd1);
        @(negedge clk);
        check("R8 enable clear drops request", {31'd0, irq_valid}, 32'd0);
        rd(6'h02, d); check("R8 pending kept after disable", d, 32'd1 << 12);
        wr(6'h02, 32'd1 << 12);
        rd(6'h02, d); check("R10 clear-pending write", d, 32'd0);
        wr(6'h00, 32'd1 << 12);
        settle();
        check("R10 cleared line stays idle", {31'd0, irq_valid}, 32'd0);
        cleanup();

        // R10 acknowledge, edge-only pending
        wr(6'h24, 32'h20);
        wr(6'h28, 32'h40);
        wr(6'h00, (32'd1 << 4) | (32'd1 << 8));
        @(negedge clk);
        irq_req = (32'd1 << 4) | (32'd1 << 8);
        @(negedge clk);
        irq_req = 32'd1 << 4;
        settle();
        check("R1 first winner", {24'd0, exc_num}, 32'd20);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        @(negedge clk);
        check("R10 next winner after ack", {24'd0, exc_num}, 32'd24);
        rd(6'h02, d); check("R10 held level not re-pended", d, 32'd1 << 8);
        irq_req = '0;
        wr(6'h24, 32'h0);
        wr(6'h28, 32'h0);
        cleanup();

        // R5 relocation and R4 address
        wr(6'h03, 32'h2000_0003);
        rd(6'h03, d); check("R5 base low bits zero", d, 32'h2000_0000);
        wr(6'h00, 32'd1 << 10);
        pulse(32'd1 << 10);
        settle();
        check("R3 line 10 exc", {24'd0, exc_num}, 32'd26);
        check("R4 relocated vector", vec_addr, 32'h2000_0068);

        // R9 non-maskable over all masking
        wr(6'h04, 32'h0000_0120);
        settle();
        check("R6 masked device idle", {31'd0, irq_valid}, 32'd0);
        @(negedge clk); nmi = 1'b1;
        @(negedge clk);
        check("R9 nmi valid", {31'd0, irq_valid}, 32'd1);
        check("R9 nmi exc", {24'd0, exc_num}, 32'd2);
        check("R4 nmi vector", vec_addr, 32'h2000_0008);
        nmi = 1'b0;
        settle();
        check("R6 back to masked", {31'd0, irq_valid}, 32'd0);
        wr(6'h04, 32'h0);
        settle();
        check("R6 unmask restores line 10", {24'd0, exc_num}, 32'd26);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule